// File: doc/BRIEF.md
# Phase-Gated Banked Word Memory

A cycle-level model of a 2048-word by 32-bit memory split into sixteen banks. Each bank stores 64 rows of 64 bits, and each row packs two 32-bit words side by side. The address, the write data and the read and write strobes are captured on the rising clock edge. The work of the cycle then runs on the two clock phases. The high phase precharges the selected bank when a read is pending. The low phase raises the word line of the addressed row and commits any write. For a read, the low phase also enables sensing in the selected bank only.

The model has no tri-state bus. Instead, a read-valid flag stands in for the driven state of the output. The flag is high only while the enabled bank is sensing, that is, in the low half of a read cycle. At all other times the read data is forced to zero. The remaining fifteen banks see no precharge, no word line and no sense enable in that cycle.

Top module: `phased_sram`

## Requirements
- R1: The captured address decodes as follows: bits 3:0 give the bank (0 to 15), bit 4 gives the word within the row (0 is the low 32 bits, 1 is the high 32 bits), and bits 10:5 give the row (0 to 63). No two distinct addresses alias.
- R2: rd_valid is high only during the low clock phase of a cycle that captured a read. Whenever rd_valid is low, rd_data is zero. This includes the whole high phase of every cycle.
- R3: A read returns the word held at the addressed bank, row and word position.
- R4: A write replaces only the addressed 32-bit half of the row. The other half keeps its value.
- R5: When both strobes are captured high, the write is performed and rd_valid stays low for that cycle.
- R6: When both strobes are captured low, the cycle is a no-operation. The memory is unchanged and rd_valid stays low, whatever the address and write data are.
- R7: During an access exactly one bank enable is high, and during a no-operation none is high. A bank that is not enabled never precharges, never senses and never stores data.
- R8: Global precharge is high only in the high clock phase of a read cycle. Global sense enable is high only in the low phase of a read cycle. The per-bank versions of both are gated by that bank's enable.
- R9: During an access the row word lines are one-hot in the low phase, and they are all low in the high phase.
- R10: While reset is asserted, and right after it is released, rd_valid is low, rd_data is zero and no access is pending.
- R11: A write is committed within its own cycle, so a read captured on the next edge returns the new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. High phase precharges, low phase drives word lines, senses and writes |
| rst_n | input | 1 | Asynchronous active-low reset of the captured strobes and address |
| addr | input | 11 | Word address: row in 10:5, word position in 4, bank in 3:0 |
| wr_data | input | 32 | Data to store on a write |
| rd_en | input | 1 | Read strobe, captured on the rising edge |
| wr_en | input | 1 | Write strobe, captured on the rising edge, takes priority over rd_en |
| rd_data | output | 32 | Read word while rd_valid is high, zero otherwise |
| rd_valid | output | 1 | High while the selected bank drives its sensed word |

## Verification
A wrong bank or row decode is first seen at a read of another location. Two locations that differ only in bank, row or word position read back each other's data one cycle after the write that was supposed to separate them. A control signal asserted in the wrong phase shows up in the same cycle: either rd_valid rises during the high phase, or a read that is blocked by a write or a no-operation raises rd_valid. A half-row write that corrupts its neighbour shows up at the next read of the other half. A no-operation that stores data shows up at the next read of the same address.

// File: rtl/psram_pkg.sv
package psram_pkg;

   // Phase-level control bundle shared by the control and bank logic
   typedef struct packed {
      logic prech;   // precharge, high phase of a read cycle
      logic sense;   // sense enable, low phase of a read cycle
      logic idle;    // no strobe captured this cycle
      logic wr;      // write captured this cycle (wins over read)
   } phase_ctrl_t;

   function automatic int unsigned log2c(input int unsigned n);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < n) r++;
      return r;
   endfunction

endpackage

// File: rtl/psram_decode.sv
module psram_decode #(
   parameter int unsigned BANKS  = 16,
   parameter int unsigned ROWS   = 64,
   parameter int unsigned BANK_W = 4,
   parameter int unsigned ROW_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              access,
   input  logic [BANK_W-1:0] bank_idx,
   input  logic [ROW_W-1:0]  row_idx,
   output logic [BANKS-1:0]  bank_en,
   output logic [ROWS-1:0]   row_oh
);

   for (genvar b = 0; b < BANKS; b++) begin : g_bank_dec
      assign bank_en[b] = access && (bank_idx == BANK_W'(b));
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row_dec
      assign row_oh[r] = (row_idx == ROW_W'(r));
   end

   // R7: one bank during an access, none otherwise
   p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      access |-> $onehot(bank_en));
   p_no_bank_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !access |-> (bank_en == '0));

endmodule

// File: rtl/psram_phase.sv
module psram_phase
   import psram_pkg::*;
#(
   parameter int unsigned ROWS = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_q,
   input  logic            wr_q,
   input  logic [ROWS-1:0] row_oh,
   output phase_ctrl_t     ctrl,
   output logic            access,
   output logic [ROWS-1:0] gwl
);

   logic rd_eff;

   // a write captured with a read suppresses the read half of the cycle
   assign rd_eff     = rd_q & ~wr_q;
   assign ctrl.prech = clk & rd_eff;
   assign ctrl.sense = rd_eff & ~clk;
   assign ctrl.idle  = ~(rd_q | wr_q);
   assign ctrl.wr    = wr_q;
   assign access     = ~ctrl.idle;

   // word lines open only in the low phase of an access
   assign gwl = (access && !clk) ? row_oh : '0;

   // R9: sampled at the rising edge, i.e. at the end of the low phase
   p_row_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      access |-> $onehot(gwl));
   // R9: sampled at the falling edge, i.e. during the high phase
   p_row_closed_high_r9: assert property (@(negedge clk) disable iff (!rst_n)
      gwl == '0);
   // R8: sense never in the high phase, precharge never in the low phase
   p_sense_low_r8: assert property (@(negedge clk) disable iff (!rst_n)
      !ctrl.sense);
   p_prech_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.prech);
   // R6: no sensing in a no-operation cycle
   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.idle |-> !ctrl.sense);

endmodule

// File: rtl/psram_bank.sv
module psram_bank
   import psram_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ROWS   = 64,
   parameter int unsigned COLS   = 2,
   parameter int unsigned ROW_W  = 6,
   parameter int unsigned COL_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bank_en,
   input  phase_ctrl_t       ctrl,
   input  logic [ROWS-1:0]   gwl,
   input  logic [ROW_W-1:0]  row_idx,
   input  logic [COL_W-1:0]  col_idx,
   input  logic [DATA_W-1:0] wdata,
   output logic              lprech,
   output logic              lsense,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned LINE_W = DATA_W * COLS;

   logic [LINE_W-1:0] cells [ROWS];
   logic [LINE_W-1:0] line_sel;
   logic [DATA_W-1:0] word_sel;
   logic              wr_local;

   assign lprech   = ctrl.prech & bank_en;
   assign lsense   = ctrl.sense & bank_en;
   assign wr_local = ctrl.wr & bank_en;

   // write commits at the start of the low phase, into one half only
   always_ff @(negedge clk) begin
      if (wr_local)
         cells[row_idx][col_idx*DATA_W +: DATA_W] <= wdata;
   end

   // word-line selected row, then column mux ahead of the sense stage
   always_comb begin
      line_sel = '0;
      for (int r = 0; r < ROWS; r++)
         if (gwl[r]) line_sel = line_sel | cells[r];
   end

   assign word_sel = line_sel[col_idx*DATA_W +: DATA_W];
   assign rdata    = lsense ? word_sel : '0;

   // R7/R8: local precharge and sense only in the enabled bank
   p_prech_gated_r8: assert property (@(negedge clk) disable iff (!rst_n)
      lprech |-> bank_en);
   p_sense_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lsense |-> bank_en);
   p_quiet_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lsense |-> (rdata == '0));

endmodule

// File: rtl/phased_sram.sv
module phased_sram
   import psram_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned BANKS  = 16,
   parameter int unsigned ROWS   = 64,
   parameter int unsigned COLS   = 2,
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic              wr_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid
);

   localparam int unsigned BANK_W = log2c(BANKS);
   localparam int unsigned COL_W  = log2c(COLS);
   localparam int unsigned ROW_W  = log2c(ROWS);
   localparam int unsigned COL_LO = BANK_W;
   localparam int unsigned ROW_LO = BANK_W + COL_W;

   if (ADDR_W != BANK_W + COL_W + ROW_W)
      $error("address width must equal bank, column and row field widths");
   if (COLS < 2 || (1 << COL_W) != COLS)
      $error("COLS must be a power of two of at least 2");
   if ((1 << BANK_W) != BANKS || (1 << ROW_W) != ROWS)
      $error("BANKS and ROWS must be powers of two");

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wd_q;
   logic              rd_q;
   logic              wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         wd_q   <= '0;
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
      end else begin
         addr_q <= addr;
         wd_q   <= wr_data;
         rd_q   <= rd_en;
         wr_q   <= wr_en;
      end
   end

   logic [BANK_W-1:0] bank_idx;
   logic [COL_W-1:0]  col_idx;
   logic [ROW_W-1:0]  row_idx;

   assign bank_idx = addr_q[BANK_W-1:0];
   assign col_idx  = addr_q[COL_LO +: COL_W];
   assign row_idx  = addr_q[ROW_LO +: ROW_W];

   phase_ctrl_t      ctrl;
   logic             access;
   logic [ROWS-1:0]  row_oh;
   logic [ROWS-1:0]  gwl;
   logic [BANKS-1:0] bank_en;
   logic [BANKS-1:0] lprech_v;
   logic [BANKS-1:0] lsense_v;
   logic [DATA_W-1:0] bank_out [BANKS];

   psram_decode #(
      .BANKS(BANKS), .ROWS(ROWS), .BANK_W(BANK_W), .ROW_W(ROW_W)
   ) u_decode (
      .clk(clk), .rst_n(rst_n), .access(access),
      .bank_idx(bank_idx), .row_idx(row_idx),
      .bank_en(bank_en), .row_oh(row_oh)
   );

   psram_phase #(.ROWS(ROWS)) u_phase (
      .clk(clk), .rst_n(rst_n), .rd_q(rd_q), .wr_q(wr_q),
      .row_oh(row_oh), .ctrl(ctrl), .access(access), .gwl(gwl)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      psram_bank #(
         .DATA_W(DATA_W), .ROWS(ROWS), .COLS(COLS),
         .ROW_W(ROW_W), .COL_W(COL_W)
      ) u_bank (
         .clk(clk), .rst_n(rst_n), .bank_en(bank_en[b]), .ctrl(ctrl),
         .gwl(gwl), .row_idx(row_idx), .col_idx(col_idx), .wdata(wd_q),
         .lprech(lprech_v[b]), .lsense(lsense_v[b]), .rdata(bank_out[b])
      );
   end

   // shared output wire: only the sensing bank contributes
   always_comb begin
      rd_data = '0;
      for (int b = 0; b < BANKS; b++)
         rd_data = rd_data | bank_out[b];
   end

   assign rd_valid = |lsense_v;

   // R2: never driven during the high phase (falling edge samples high phase)
   p_no_drive_high_r2: assert property (@(negedge clk) disable iff (!rst_n)
      !rd_valid && rd_data == '0);
   // R5: a captured write keeps the output undriven
   p_write_blocks_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> !rd_valid);
   // R7: at most one bank precharging or sensing
   p_single_prech_r7: assert property (@(negedge clk) disable iff (!rst_n)
      $onehot0(lprech_v));
   p_single_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lsense_v));

endmodule

// File: tb/phased_sram_bench.sv
module phased_sram_bench;

   typedef struct {
      logic        valid;
      logic [31:0] data;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] rd_data;
   logic        rd_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   exp_t        sb_q [$];
   logic [63:0] ref_mem [1024];

   always #5 clk = ~clk;

   phased_sram u_phased_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
      .rd_en(rd_en), .wr_en(wr_en), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   function automatic logic [10:0] mk(input int row, input int col, input int bank);
      return {row[5:0], col[0], bank[3:0]};
   endfunction

   task automatic check(input string tag, input logic [32:0] act, input logic [32:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual valid=%0b data=%08h expected valid=%0b data=%08h",
                  tag, act[32], act[31:0], exp[32], exp[31:0]);
      end
   endtask

   // driver: sets the inputs between edges and records the expectation
   task automatic op(input logic r, input logic w, input logic [10:0] a,
                     input logic [31:0] d, input string tag);
      exp_t e;
      int   idx;
      @(negedge clk); #1;
      rd_en = r; wr_en = w; addr = a; wr_data = d;
      idx = {a[10:5], a[3:0]};
      e.tag = tag;
      e.valid = 1'b0;
      e.data = '0;
      if (w) begin
         if (a[4]) ref_mem[idx][63:32] = d;
         else      ref_mem[idx][31:0]  = d;
      end else if (r) begin
         e.valid = 1'b1;
         e.data = a[4] ? ref_mem[idx][63:32] : ref_mem[idx][31:0];
      end
      sb_q.push_back(e);
   endtask

   // monitor: high phase must be quiet, low phase carries the result
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            #2;
            check({e.tag, " R2 R8 high phase"}, {rd_valid, rd_data}, 33'd0);
            #5;
            e = sb_q.pop_front();
            check(e.tag, {rd_valid, rd_data}, {e.valid, e.data});
         end
      end
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 5000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #7;
      check("R10 in reset", {rd_valid, rd_data}, 33'd0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      @(posedge clk); #7;
      check("R10 after release", {rd_valid, rd_data}, 33'd0);

      // R3 R4: both halves of one row
      op(0, 1, mk(5, 0, 2), 32'hAAAA_0001, "R4 write low half");
      op(0, 1, mk(5, 1, 2), 32'hBBBB_0002, "R4 write high half");
      op(1, 0, mk(5, 0, 2), 0, "R3 R4 read low half kept");
      op(1, 0, mk(5, 1, 2), 0, "R3 R9 read high half");
      // R7 R1: neighbour bank, same row and column
      op(0, 1, mk(5, 0, 3), 32'hCCCC_0003, "R7 write bank 3");
      op(1, 0, mk(5, 0, 2), 0, "R7 R1 bank 2 untouched");
      op(1, 0, mk(5, 0, 3), 0, "R1 read bank 3");
      // R1 corner addresses
      op(0, 1, mk(63, 1, 15), 32'hF00D_BEEF, "R1 write top corner");
      op(0, 1, mk(0, 0, 0), 32'h1234_5678, "R1 write bottom corner");
      op(1, 0, mk(63, 1, 15), 0, "R1 read top corner");
      op(1, 0, mk(0, 0, 0), 0, "R1 read bottom corner");
      // R11 back to back
      op(0, 1, mk(17, 1, 9), 32'h0BAD_CAFE, "R11 write");
      op(1, 0, mk(17, 1, 9), 0, "R11 read next cycle");
      // R5 read and write together
      op(1, 1, mk(17, 1, 9), 32'h5555_AAAA, "R5 both strobes undriven");
      op(1, 0, mk(17, 1, 9), 0, "R5 write took effect");
      // R6 no-operation with live address and data
      op(0, 0, mk(17, 1, 9), 32'hDEAD_DEAD, "R6 idle undriven");
      op(1, 0, mk(17, 1, 9), 0, "R6 memory unchanged");
      // R1 R7 every bank, same row
      for (int b = 0; b < 16; b++)
         op(0, 1, mk(40, b % 2, b), 32'h7000_0000 + b * 32'h0101, "R7 fill");
      for (int b = 15; b >= 0; b--)
         op(1, 0, mk(40, b % 2, b), 0, "R1 R7 bank isolation");
      op(0, 0, 0, 0, "R6 final idle");
      repeat (4) @(posedge clk);
      #8;
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule